// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Registers and Status

This block holds the digital control of a multi-channel analog-to-digital converter. A sequence starts when software writes the sequence register, or when a rising edge arrives on the external trigger input while triggering is enabled. The block then asks an abstract converter for one sample per step. The first step uses the programmed start channel, and each later step uses the next channel, wrapping modulo 8. Each 10-bit sample is turned into a left-justified 16-bit word, either unsigned or signed, at 10 or 8 bits of precision. The word is stored in the result slot named by a 3-bit conversion counter.

A status byte reports three things. It holds a completion flag, a flag for a trigger that came while a sequence was still running, and a flag for a result slot overwritten before it was read in FIFO mode. It also shows the conversion counter. In normal mode the counter returns to 0 at both ends of a sequence. In FIFO mode it runs on and wraps, so that consecutive sequences fill the slots like a ring.

The converter interface is a request/response pair with no back-pressure. `conv_req` acts as the valid of a request, and `conv_chan` stays stable while it is high. The converter answers with a one-cycle `conv_done` that carries `conv_data`. The block takes that pulse as the end of the step. A `conv_done` while `conv_req` is low is ignored. The register port is a plain strobe interface. Reads are combinational and take effect in the same cycle. The side effects of a read, such as clearing a flag, take effect at the clock edge.

Top module: `adc_seq_ctrl`

Register map (4-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | Configuration | bit0 FIFO mode, bit1 fast clear, bit2 signed, bit3 8-bit precision, bit4 trigger enable |
| 1 | Sequence | bits 2:0 start channel, bits 5:3 length minus one; a write starts a sequence |
| 2 | Status | see R12 |
| 8–15 | Result slots | slots 0–7, read only |

## Requirements
- R1: After reset the status byte reads 0x00 and `conv_req` is low.
- R2: A write to address 1 starts a sequence, and `conv_req` goes high in the next cycle with `conv_chan` equal to bits 2:0 of the written value. Such a write also clears the completion flag, even when a sequence is running, and the running sequence is then restarted.
- R3: A sequence makes (bits 5:3 + 1) conversions. After each accepted `conv_done`, `conv_chan` advances by one modulo 8.
- R4: An unsigned 10-bit sample `d` is stored as `{d, 6'b0}` (0x3FF gives 0xFFC0, 0x200 gives 0x8000). With 8-bit precision (config bit3) the stored value is `{d[9:2], 8'b0}`.
- R5: The signed format (config bit2) is the unsigned word with bit 15 inverted (0x3FF gives 0x7FC0, 0x200 gives 0x0000, 0x000 gives 0x8000).
- R6: Each result goes to the slot given by the counter, and the counter then increments. In normal mode the counter is 0 at the start of a sequence and is set to 0 when the sequence ends.
- R7: In FIFO mode (config bit0) the counter is never reset at sequence boundaries, and it wraps from 7 to 0.
- R8: Status bit 7 sets when the last conversion of a sequence completes. With fast clear (config bit1) set, reading any result slot clears it.
- R9: With fast clear off, a result read leaves bit 7 unchanged. Writing status with bit 7 = 1 clears it, and writing status with bit 7 = 0 leaves it set.
- R10: A rising edge on `ext_trig` with config bit4 set starts a sequence when none is active. An edge while a sequence is active is ignored and sets status bit 5, which clears on a status write with bit 5 = 1.
- R11: In FIFO mode, writing a slot whose last value was never read sets status bit 4. A status write with bit 4 = 1 clears it.
- R12: The status byte is {bit7 complete, 0, bit5 trigger overrun, bit4 FIFO overrun, 0, bits 2:0 counter}. Software writes never change the counter bits. When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| ext_trig | input | 1 | External trigger, rising edge active |
| conv_req | output | 1 | Conversion request, high while a sequence runs |
| conv_chan | output | 3 | Channel of the requested conversion |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | 10 | Raw sample, valid with `conv_done` |

## Verification
The bench builds the block with its default parameters: 10-bit samples, 16-bit words, 8 result slots and 3-bit channel and length fields. With these values a sequence of up to eight conversions can run from any start channel. This brings the channel wrap from 7 to 0, the counter wrap in FIFO mode and the overwrite of an unread slot within reach of short runs. Random sequences change the start channel, the length, the sample format and the fast-clear mode. Directed cases cover the format corners, trigger overrun and the flag-clearing rules.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RAW_W  = 10;
  localparam int WORD_W = 16;
  localparam int CH_W   = 3;
  localparam int LEN_W  = 3;
  localparam int SLOTS  = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG  = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEQ  = 4'h1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h2;

  localparam int CFG_FIFO = 0;
  localparam int CFG_FAST = 1;
  localparam int CFG_SGN  = 2;
  localparam int CFG_8B   = 3;
  localparam int CFG_TRIG = 4;
  localparam int CFG_W    = 5;

  localparam int ST_SCF   = 7;
  localparam int ST_ETORF = 5;
  localparam int ST_FOVR  = 4;
endpackage

// File: rtl/adc_fmt.sv
module adc_fmt #(
  parameter int RAW_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic              eight_bit,
  input  logic              signed_fmt,
  output logic [WORD_W-1:0] word
);
  localparam int PAD10 = WORD_W - RAW_W;
  localparam int PAD8  = WORD_W - 8;
  logic [WORD_W-1:0] uns;

  always_comb begin
    if (eight_bit) uns = {raw[RAW_W-1 -: 8], {PAD8{1'b0}}};
    else           uns = {raw, {PAD10{1'b0}}};
    word = uns;
    if (signed_fmt) word[WORD_W-1] = ~uns[WORD_W-1];
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int CH_W  = 3,
  parameter int LEN_W = 3,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  start_chan,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             fifo_mode,
  input  logic             conv_done,
  output logic             busy,
  output logic [CH_W-1:0]  chan,
  output logic [IDX_W-1:0] ctr,
  output logic             res_we,
  output logic [IDX_W-1:0] res_idx,
  output logic             seq_done
);
  logic [LEN_W-1:0] remain;
  logic acc, last;

  assign acc      = busy && conv_done;
  assign last     = (remain == '0);
  assign res_we   = acc && !start;
  assign res_idx  = ctr;
  assign seq_done = acc && last && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      chan   <= '0;
      remain <= '0;
      ctr    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      chan   <= start_chan;
      remain <= len_m1;
      if (!fifo_mode) ctr <= '0;
    end else if (acc) begin
      chan <= chan + 1'b1;
      if (last) begin
        busy <= 1'b0;
        ctr  <= fifo_mode ? ctr + 1'b1 : '0;
      end else begin
        remain <= remain - 1'b1;
        ctr    <= ctr + 1'b1;
      end
    end
  end

  p_chan_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !last && !start) |=> (chan == $past(chan) + 1'b1));

  p_ctr_end_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !fifo_mode) |=> (ctr == '0));

  p_fifo_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && fifo_mode && (ctr == '1)) |=> (ctr == '0));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata,
  output logic              ovf
);
  logic [WORD_W-1:0] mem    [SLOTS];
  logic              unread [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit_w, hit_r;
    assign hit_w = we && (widx == IDX_W'(i));
    assign hit_r = re && (ridx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[i]    <= '0;
        unread[i] <= 1'b0;
      end else if (hit_w) begin
        mem[i]    <= wdata;
        unread[i] <= 1'b1;
      end else if (hit_r) begin
        unread[i] <= 1'b0;
      end
    end
  end

  assign rdata = mem[ridx];
  assign ovf   = we && unread[widx];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              ext_trig,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RAW_W-1:0]  conv_data
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int SEQ_W = CH_W + LEN_W;

  logic [CFG_W-1:0] cfg_q;
  logic [SEQ_W-1:0] seq_q;
  logic             trig_q, scf, etorf, fovr;
  logic             seq_wr, cfg_wr, stat_wr, res_rd;
  logic             trig_edge, trig_start, start;
  logic             busy, res_we, seq_done, ovf;
  logic [IDX_W-1:0] ctr, res_idx;
  logic [WORD_W-1:0] fmt_word, res_rdata;
  logic [7:0]       status;

  assign cfg_wr  = reg_wr && (reg_addr == A_CFG);
  assign seq_wr  = reg_wr && (reg_addr == A_SEQ);
  assign stat_wr = reg_wr && (reg_addr == A_STAT);
  assign res_rd  = reg_rd && reg_addr[ADDR_W-1];

  assign trig_edge  = ext_trig && !trig_q && cfg_q[CFG_TRIG];
  assign trig_start = trig_edge && !busy && !seq_wr;
  assign start      = seq_wr || trig_start;

  adc_seq_fsm #(.CH_W(CH_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_chan (seq_wr ? reg_wdata[CH_W-1:0] : seq_q[CH_W-1:0]),
    .len_m1     (seq_wr ? reg_wdata[SEQ_W-1:CH_W] : seq_q[SEQ_W-1:CH_W]),
    .fifo_mode  (cfg_q[CFG_FIFO]),
    .conv_done  (conv_done),
    .busy       (busy),
    .chan       (conv_chan),
    .ctr        (ctr),
    .res_we     (res_we),
    .res_idx    (res_idx),
    .seq_done   (seq_done)
  );

  adc_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
    .raw        (conv_data),
    .eight_bit  (cfg_q[CFG_8B]),
    .signed_fmt (cfg_q[CFG_SGN]),
    .word       (fmt_word)
  );

  adc_result_bank #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (res_we),
    .widx  (res_idx),
    .wdata (fmt_word),
    .re    (res_rd),
    .ridx  (reg_addr[IDX_W-1:0]),
    .rdata (res_rdata),
    .ovf   (ovf)
  );

  assign conv_req = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      seq_q  <= '0;
      trig_q <= 1'b0;
      scf    <= 1'b0;
      etorf  <= 1'b0;
      fovr   <= 1'b0;
    end else begin
      trig_q <= ext_trig;
      if (cfg_wr) cfg_q <= reg_wdata[CFG_W-1:0];
      if (seq_wr) seq_q <= reg_wdata[SEQ_W-1:0];

      if (seq_done)                          scf <= 1'b1;
      else if (seq_wr)                       scf <= 1'b0;
      else if (stat_wr && reg_wdata[ST_SCF]) scf <= 1'b0;
      else if (res_rd && cfg_q[CFG_FAST])    scf <= 1'b0;

      if (trig_edge && busy)                   etorf <= 1'b1;
      else if (stat_wr && reg_wdata[ST_ETORF]) etorf <= 1'b0;

      if (ovf && cfg_q[CFG_FIFO])             fovr <= 1'b1;
      else if (stat_wr && reg_wdata[ST_FOVR]) fovr <= 1'b0;
    end
  end

  assign status = {scf, 1'b0, etorf, fovr, 1'b0, ctr};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1])        reg_rdata = res_rdata;
    else if (reg_addr == A_CFG)    reg_rdata[CFG_W-1:0] = cfg_q;
    else if (reg_addr == A_SEQ)    reg_rdata[SEQ_W-1:0] = seq_q;
    else if (reg_addr == A_STAT)   reg_rdata[7:0] = status;
  end

  p_scf_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> scf);

  p_etorf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && busy) |=> (etorf && busy == $past(busy)));

  p_fovr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cfg_q[CFG_FIFO]) |=> fovr);

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !conv_req);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_trig = 1'b0;
  logic        conv_req;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_trig(ext_trig), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data)
  );

  function automatic logic [15:0] expect_word(logic [9:0] raw, logic eight, logic sgn);
    logic [15:0] u;
    if (eight) u = 16'((raw >> 2) * 256);
    else       u = 16'(raw * 64);
    return sgn ? (u ^ 16'h8000) : u;
  endfunction

  function automatic logic [15:0] seqv(int start, int len);
    return 16'(((len - 1) << 3) | start);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic conv(logic [9:0] raw, logic [2:0] exp_ch, string tag);
    chk({tag, " req"}, {15'b0, conv_req}, 16'h1);
    chk({tag, " chan"}, {13'b0, conv_chan}, {13'b0, exp_ch});
    conv_done = 1'b1; conv_data = raw;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse_trig();
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic fmt_case(logic [15:0] cfgv, logic [9:0] raw, logic [15:0] exp, string tag);
    wr(4'h0, cfgv);
    wr(4'h1, seqv(0, 1));
    conv(raw, 3'd0, tag);
    rd_chk(tag, 4'h8, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [9:0]  raws [8];
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 status", 4'h2, 16'h0000);
    chk("R1 conv_req", {15'b0, conv_req}, 16'h0);

    // R4 / R5 format corners
    fmt_case(16'h0000, 10'h3FF, 16'hFFC0, "R4 full unsigned");
    fmt_case(16'h0000, 10'h200, 16'h8000, "R4 mid unsigned");
    fmt_case(16'h0008, 10'h3FF, 16'hFF00, "R4 8bit full");
    fmt_case(16'h0004, 10'h3FF, 16'h7FC0, "R5 full signed");
    fmt_case(16'h0004, 10'h200, 16'h0000, "R5 mid signed");
    fmt_case(16'h0004, 10'h000, 16'h8000, "R5 zero signed");
    fmt_case(16'h000C, 10'h3FF, 16'h7F00, "R5 8bit signed");

    // R2 / R3 channel stepping with wrap
    wr(4'h0, 16'h0000);
    wr(4'h1, seqv(6, 4));
    rd_chk("R2 scf cleared on start", 4'h2, 16'h0000);
    conv(10'h011, 3'd6, "R2 first");
    conv(10'h022, 3'd7, "R3 step");
    conv(10'h033, 3'd0, "R3 wrap");
    conv(10'h044, 3'd1, "R3 last");
    chk("R3 length done", {15'b0, conv_req}, 16'h0);
    rd_chk("R6 slot3", 4'hB, expect_word(10'h044, 0, 0));

    // R8 / R9 flag clearing
    rd_chk("R9 read no clear", 4'h8, expect_word(10'h011, 0, 0));
    rd_chk("R9 scf kept", 4'h2, 16'h0080);
    wr(4'h2, 16'h0000);
    rd_chk("R9 write0 keeps", 4'h2, 16'h0080);
    wr(4'h2, 16'h0080);
    rd_chk("R9 write1 clears", 4'h2, 16'h0000);
    wr(4'h1, seqv(0, 1));
    conv(10'h100, 3'd0, "R8 run");
    rd_chk("R8 scf set", 4'h2, 16'h0080);
    wr(4'h0, 16'h0002);
    rd(4'h9, d);
    rd_chk("R8 fast clear", 4'h2, 16'h0000);
    wr(4'h0, 16'h0000);
    wr(4'h1, seqv(2, 2));
    conv(10'h100, 3'd2, "R2 a");
    conv(10'h100, 3'd3, "R2 b");
    wr(4'h1, seqv(5, 2));
    rd_chk("R2 seq write clears scf", 4'h2, 16'h0000);
    wr(4'h1, seqv(1, 2));
    conv(10'h155, 3'd1, "R2 restart");
    conv(10'h0AA, 3'd2, "R2 restart b");
    rd_chk("R2 restarted data", 4'h8, expect_word(10'h155, 0, 0));

    // drain unread flags before FIFO mode
    for (int i = 0; i < 8; i++) rd(4'(8 + i), d);

    // R7 / R11 FIFO mode
    wr(4'h0, 16'h0001);
    wr(4'h1, seqv(0, 3));
    for (int i = 0; i < 3; i++) conv(10'(i + 1), 3'(i), "R7 first");
    rd_chk("R7 ctr kept", 4'h2, 16'h0083);
    wr(4'h1, seqv(3, 6));
    for (int i = 0; i < 6; i++) begin
      raws[i] = 10'($urandom);
      conv(raws[i], 3'(3 + i), "R7 second");
    end
    rd_chk("R11 overrun + R7 wrap", 4'h2, 16'h0091);
    rd_chk("R7 wrapped slot0", 4'h8, expect_word(raws[5], 0, 0));
    rd_chk("R7 slot7", 4'hF, expect_word(raws[4], 0, 0));
    wr(4'h2, 16'h0017);
    rd_chk("R12 counter unwritable, R11 clear", 4'h2, 16'h0081);

    // R6 normal mode resets counter at start
    wr(4'h0, 16'h0000);
    wr(4'h1, seqv(4, 2));
    rd_chk("R6 start zero", 4'h2, 16'h0000);
    conv(10'h0F0, 3'd4, "R6 a");
    rd_chk("R6 mid count", 4'h2, 16'h0001);
    conv(10'h00F, 3'd5, "R6 b");
    rd_chk("R6 end zero", 4'h2, 16'h0080);
    rd_chk("R6 slot0", 4'h8, expect_word(10'h0F0, 0, 0));
    rd_chk("R6 slot1", 4'h9, expect_word(10'h00F, 0, 0));
    wr(4'h2, 16'h0080);

    // R10 trigger and trigger overrun
    wr(4'h1, seqv(6, 3));
    conv(10'h001, 3'd6, "R10 setup a");
    conv(10'h002, 3'd7, "R10 setup b");
    conv(10'h003, 3'd0, "R10 setup c");
    wr(4'h2, 16'h0080);
    pulse_trig();
    chk("R10 trigger ignored when disabled", {15'b0, conv_req}, 16'h0);
    wr(4'h0, 16'h0010);
    ext_trig = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    conv(10'h3C0, 3'd6, "R10 trig start");
    pulse_trig();
    rd_chk("R10 overrun", 4'h2, 16'h0021);
    conv(10'h3C1, 3'd7, "R10 b");
    conv(10'h3C2, 3'd0, "R10 c");
    chk("R10 extra trigger ignored", {15'b0, conv_req}, 16'h0);
    rd_chk("R10 status end", 4'h2, 16'h00A0);
    wr(4'h2, 16'h00A0);
    rd_chk("R10 cleared", 4'h2, 16'h0000);

    // random sequences (R3 R4 R5 R6 R8 R9)
    for (int it = 0; it < 30; it++) begin
      int st, len;
      logic eight, sgn, fast;
      st = int'($urandom % 8);
      len = int'($urandom % 8) + 1;
      eight = 1'($urandom); sgn = 1'($urandom); fast = 1'($urandom);
      wr(4'h0, {12'b0, eight, sgn, fast, 1'b0});
      wr(4'h1, seqv(st, len));
      for (int k = 0; k < len; k++) begin
        raws[k] = 10'($urandom);
        conv(raws[k], 3'((st + k) % 8), "R3 random chan");
      end
      rd_chk("R6 random end", 4'h2, 16'h0080);
      for (int k = 0; k < len; k++)
        rd_chk("R4 random word", 4'(8 + k), expect_word(raws[k], eight, sgn));
      rd_chk("R8 random flag", 4'h2, fast ? 16'h0000 : 16'h0080);
      wr(4'h2, 16'h0080);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule